// File: doc/BRIEF.md
# Hardware Breakpoint Status Evaluator

This block decides which of a small set of hardware breakpoint slots fired on the current step, and keeps the debug status word that a trap handler reads. Each slot has an address and a two-bit kind taken from a packed control word. An instruction-kind slot fires when its address equals the program counter. A data-kind slot fires when its own watch-hit flag is raised by the load/store unit. An I/O-kind slot never fires.

When the evaluate strobe is high, the block builds a working status word. It starts from the held status with its slot bits cleared, then sets the bit of every slot that fired, whether that slot is enabled or not. The working word is stored only if an enabled slot fired or the force input is high. Otherwise the held status keeps its value. When an enabled slot fired, a one-cycle trap request follows. Upper status bits are never touched by an evaluation, so they keep their reset value.

Top module: `dbg_bp_eval`

## Requirements
- R1: After reset, `status_o` equals the parameter `STAT_RESET` (default 0xFFFF0FF0) and `trap_o` is 0.
- R2: Slot n is enabled when `ctrl_i` bit 2n or bit 2n+1 is set. Either bit alone is enough.
- R3: The kind of slot n is `ctrl_i[17+4n:16+4n]`. Kind 0 (instruction) fires exactly when address n equals `pc_i`, and its watch flag has no effect.
- R4: Kind 1 (data write) and kind 3 (data read/write) fire exactly when `watch_hit_i[n]` is 1, whatever `pc_i` is.
- R5: Kind 2 (I/O) never fires. Its status bit is 0 after any stored evaluation, even when its address equals `pc_i` and its watch flag is set.
- R6: When an evaluation is stored, `status_o[n]` for n < 4 equals 1 exactly for slots that fired. Bits 4 and up keep their previous value.
- R7: An evaluation is stored, one cycle after the strobe, only when an enabled slot fired or `force_i` is 1. Otherwise `status_o` holds, even if disabled slots fired. Slots that fired while disabled are still recorded in a stored word.
- R8: `trap_o` is 1 for exactly the one cycle after a strobe in which an enabled slot fired. It is never raised by `force_i` alone.
- R9: While `eval_i` is 0, `status_o` and `trap_o` do not change from their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_addr_i | input | 128 | Slot addresses; slot n in bits [32n+31:32n] |
| ctrl_i | input | 32 | Enable pairs in bits [7:0], kind fields from bit 16 |
| pc_i | input | 32 | Current program counter |
| watch_hit_i | input | 4 | Per-slot data-watch hit flags |
| eval_i | input | 1 | Evaluate strobe, one step per high cycle |
| force_i | input | 1 | Store the working status even without an enabled hit |
| status_o | output | 32 | Held debug status word |
| trap_o | output | 1 | Debug-exception request pulse |

## Verification
The properties assume that the strobe, force, control, address and flag inputs are stable around the rising edge. They also assume that any change of `status_o` comes only from a strobe cycle. The stimulus meets this by driving every input on the falling edge and holding it for a full cycle. The stimulus lowers the strobe between steps, so each trap pulse stands alone. It also raises force only together with the strobe when a stored word with no trap is wanted.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

    typedef enum logic [1:0] {
        KIND_EXEC   = 2'd0,
        KIND_WRITE  = 2'd1,
        KIND_PORT   = 2'd2,
        KIND_ACCESS = 2'd3
    } bp_kind_e;

    localparam int KIND_W       = 2;
    localparam int FIELD_BASE   = 16;
    localparam int FIELD_STRIDE = 4;
    localparam int EN_STRIDE    = 2;

endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
    import dbg_bp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              watch_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [1:0]        en_i,
    output logic              fired_o,
    output logic              armed_o
);

    bp_kind_e kind;

    always_comb begin
        kind = bp_kind_e'(kind_i);
        unique case (kind)
            KIND_EXEC:   fired_o = (addr_i == pc_i);
            KIND_WRITE:  fired_o = watch_i;
            KIND_ACCESS: fired_o = watch_i;
            default:     fired_o = 1'b0;
        endcase
        armed_o = fired_o && (|en_i);
    end

endmodule

// File: rtl/dbg_bp_merge.sv
module dbg_bp_merge #(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0] fired_i,
    input  logic [NUM_SLOTS-1:0] armed_i,
    output logic [NUM_SLOTS-1:0] hit_mask_o,
    output logic                 any_armed_o
);

    always_comb begin
        hit_mask_o  = fired_i;
        any_armed_o = |armed_i;
    end

endmodule

// File: rtl/dbg_bp_eval.sv
module dbg_bp_eval
    import dbg_bp_pkg::*;
#(
    parameter int          NUM_SLOTS  = 4,
    parameter int          ADDR_W     = 32,
    parameter int          STAT_W     = 32,
    parameter logic [31:0] STAT_RESET = 32'hFFFF_0FF0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SLOTS*ADDR_W-1:0]   bp_addr_i,
    input  logic [FIELD_BASE+FIELD_STRIDE*NUM_SLOTS-1:0] ctrl_i,
    input  logic [ADDR_W-1:0]             pc_i,
    input  logic [NUM_SLOTS-1:0]          watch_hit_i,
    input  logic                          eval_i,
    input  logic                          force_i,
    output logic [STAT_W-1:0]             status_o,
    output logic                          trap_o
);

    localparam int UPPER_W = STAT_W - NUM_SLOTS;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              trap;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_SLOTS-1:0] fired;
    logic [NUM_SLOTS-1:0] armed;
    logic [NUM_SLOTS-1:0] hit_mask;
    logic                 any_armed;
    logic [STAT_W-1:0]    work_status;

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        dbg_bp_slot #(
            .ADDR_W (ADDR_W)
        ) u_slot (
            .addr_i  (bp_addr_i[n*ADDR_W +: ADDR_W]),
            .pc_i    (pc_i),
            .watch_i (watch_hit_i[n]),
            .kind_i  (ctrl_i[FIELD_BASE + FIELD_STRIDE*n +: KIND_W]),
            .en_i    (ctrl_i[EN_STRIDE*n +: EN_STRIDE]),
            .fired_o (fired[n]),
            .armed_o (armed[n])
        );
    end

    dbg_bp_merge #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_merge (
        .fired_i     (fired),
        .armed_i     (armed),
        .hit_mask_o  (hit_mask),
        .any_armed_o (any_armed)
    );

    always_comb begin
        state_d      = state_q;
        state_d.trap = 1'b0;
        work_status  = {state_q.status[STAT_W-1 -: UPPER_W], hit_mask};
        if (eval_i) begin
            if (any_armed || force_i) begin
                state_d.status = work_status;
            end
            state_d.trap = any_armed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.status <= STAT_RESET[STAT_W-1:0];
            state_q.trap   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.status;
    assign trap_o   = state_q.trap;

endmodule

// File: rtl/dbg_bp_eval_chk.sv
module dbg_bp_eval_chk
    import dbg_bp_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int STAT_W    = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [FIELD_BASE+FIELD_STRIDE*NUM_SLOTS-1:0] ctrl_i,
    input logic                  eval_i,
    input logic                  force_i,
    input logic [STAT_W-1:0]     status_o,
    input logic                  trap_o
);

    // R8: a trap pulse always follows a strobe cycle
    assert_trap_after_eval_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(eval_i));

    // R9: no strobe, no change of the status word
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable(status_o));

    // R7: an unforced strobe changes status only together with a trap
    assert_commit_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !force_i) |=> ($stable(status_o) || trap_o));

    // R6: a trap implies at least one slot bit is recorded
    assert_trap_has_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (status_o[NUM_SLOTS-1:0] != '0));

    // R6: bits above the slot field never move
    assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(status_o[STAT_W-1:NUM_SLOTS]));

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_port
        // R5: an I/O-kind slot is clear after a forced store
        assert_port_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (eval_i && force_i &&
             ctrl_i[FIELD_BASE + FIELD_STRIDE*n +: KIND_W] == KIND_PORT)
            |=> !status_o[n]);
    end

endmodule

bind dbg_bp_eval dbg_bp_eval_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .STAT_W    (STAT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_i   (ctrl_i),
    .eval_i   (eval_i),
    .force_i  (force_i),
    .status_o (status_o),
    .trap_o   (trap_o)
);

// File: tb/dbg_bp_eval_test.sv
`timescale 1ns/1ps
module dbg_bp_eval_test;

    localparam int NV = 10;
    // fields: ctrl, pc, watch, force, exp_lo, exp_commit, exp_trap, req
    localparam logic [78:0] VECS [0:NV-1] = '{
        // R3 R2: exec slot0, local enable, pc hits
        {32'h0000_0001, 32'h0000_1000, 4'b0000, 1'b0, 4'b0001, 1'b1, 1'b1, 4'd3},
        // R7: disabled slot1 fires, slot0 (global) misses -> hold
        {32'h0000_0002, 32'h0000_2000, 4'b0000, 1'b0, 4'b0001, 1'b0, 1'b0, 4'd7},
        // R7: same with force -> stored, no trap
        {32'h0000_0002, 32'h0000_2000, 4'b0000, 1'b1, 4'b0010, 1'b1, 1'b0, 4'd7},
        // R4: slot1 data write kind, watch flag
        {32'h0010_0004, 32'h0000_0000, 4'b0010, 1'b0, 4'b0010, 1'b1, 1'b1, 4'd4},
        // R4 R2: slot3 read/write kind, global enable
        {32'h3000_0080, 32'h0000_0000, 4'b1000, 1'b0, 4'b1000, 1'b1, 1'b1, 4'd4},
        // R5: slot2 I/O kind, pc and flag both match, forced
        {32'h0200_0030, 32'h0000_3000, 4'b0100, 1'b1, 4'b0000, 1'b1, 1'b0, 4'd5},
        // R6: two slots fire together
        {32'h0010_0005, 32'h0000_1000, 4'b0010, 1'b0, 4'b0011, 1'b1, 1'b1, 4'd6},
        // R3: watch flag on exec slot ignored
        {32'h0000_0001, 32'h0000_0000, 4'b0001, 1'b0, 4'b0011, 1'b0, 1'b0, 4'd3},
        // R7: disabled slot3 recorded beside enabled slot0
        {32'h1000_0001, 32'h0000_1000, 4'b1000, 1'b0, 4'b1001, 1'b1, 1'b1, 4'd7},
        // R8: exec hit with nothing enabled -> no trap, hold
        {32'h0000_0000, 32'h0000_1000, 4'b0000, 1'b0, 4'b1001, 1'b0, 1'b0, 4'd8}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] bp_addr_i;
    logic [31:0]  ctrl_i = '0;
    logic [31:0]  pc_i = '0;
    logic [3:0]   watch_hit_i = '0;
    logic         eval_i = 1'b0;
    logic         force_i = 1'b0;
    logic [31:0]  status_o;
    logic         trap_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_status;

    always #2.5 clk = ~clk;

    assign bp_addr_i = {32'h0000_4000, 32'h0000_3000, 32'h0000_2000, 32'h0000_1000};

    dbg_bp_eval uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bp_addr_i   (bp_addr_i),
        .ctrl_i      (ctrl_i),
        .pc_i        (pc_i),
        .watch_hit_i (watch_hit_i),
        .eval_i      (eval_i),
        .force_i     (force_i),
        .status_o    (status_o),
        .trap_o      (trap_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", status_o, 32'hFFFF_0FF0);
        chk("R1 trap", {31'b0, trap_o}, 32'h0);
        exp_status = 32'hFFFF_0FF0;

        for (int i = 0; i < NV; i++) begin
            ctrl_i      = VECS[i][78:47];
            pc_i        = VECS[i][46:15];
            watch_hit_i = VECS[i][14:11];
            force_i     = VECS[i][10];
            eval_i      = 1'b1;
            @(negedge clk);
            eval_i  = 1'b0;
            force_i = 1'b0;
            if (VECS[i][5]) exp_status = {exp_status[31:4], VECS[i][9:6]};
            chk($sformatf("R%0d vec%0d status", VECS[i][3:0], i), status_o, exp_status);
            chk($sformatf("R%0d vec%0d trap", VECS[i][3:0], i), {31'b0, trap_o}, {31'b0, VECS[i][4]});
            @(negedge clk);
            // R8: pulse lasts one cycle
            chk($sformatf("R8 vec%0d pulse end", i), {31'b0, trap_o}, 32'h0);
        end

        // R9: matching inputs with no strobe leave everything alone
        ctrl_i = 32'h0000_00FF; pc_i = 32'h0000_2000; watch_hit_i = 4'hF; force_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 status", status_o, exp_status);
        chk("R9 trap", {31'b0, trap_o}, 32'h0);
        force_i = 1'b0;

        // R2: global bit of slot2 alone enables it
        ctrl_i = 32'h0000_0020; pc_i = 32'h0000_3000; watch_hit_i = '0; eval_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0;
        chk("R2 status", status_o, {exp_status[31:4], 4'b0100});
        chk("R2 trap", {31'b0, trap_o}, 32'h1);

        // R1: reset again restores the reset word
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rereset", status_o, 32'hFFFF_0FF0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule